// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors in host memory and turns the frame buffers they point at into a byte stream for a MAC transmitter. Software fills descriptors, hands each one to the engine by setting its ownership bit, and kicks the engine with a write to a poll register. The engine reads each 16-byte descriptor, streams the buffer bytes, and writes the status word back with ownership cleared so software can detect completion by polling that bit.

A frame may be split across several descriptors, opened by a first-segment flag and closed by a last-segment flag. The ring has no length register: a descriptor flagged as end-of-ring sends the next fetch back to the ring base. When the engine meets a descriptor it does not own, it stops and flags descriptor-unavailable until the next poll. Completion is reported through sticky interrupt flags that software clears by writing ones.

Top module: `txring_engine`

## Requirements
- R1: After reset the interrupt flags read zero, `busy` is low, and no memory read, memory write or stream byte is offered.
- R2: A configuration write to offset 0x38 with data bit 6 set starts fetching at the ring base; the base is set by offset 0x20 (address bits 31:8, bits 7:0 forced to zero) and offset 0x24 (address bits 63:32), and a base write while idle also moves the fetch pointer to the new base.
- R3: A descriptor is read as four 32-bit words at +0, +4, +8, +12: word 0 is status (bit 31 engine-owned, bit 30 end-of-ring, bit 29 first segment, bit 28 last segment, bits 13:0 byte length), word 1 a tag that is ignored, words 2 and 3 the low and high halves of the byte buffer address; every read address is word aligned and held until `rd_valid`.
- R4: A status word with bit 31 clear stops the engine with no write-back and no bytes, sets interrupt flag bit 7, and the next poll re-reads that same descriptor address.
- R5: The buffer bytes are sent in address order starting at any byte alignment, byte k of a word taken from bits 8k+7:8k, exactly length bytes per descriptor; `tx_last` marks only the final byte of a last-segment descriptor.
- R6: After a descriptor's bytes are all accepted, its status word is written back to the descriptor address with bit 31 cleared, the other bits unchanged for a good segment.
- R7: After a descriptor with bit 30 set the next fetch is at the ring base; otherwise it is 16 bytes further on.
- R8: For a frame spread over several descriptors, `tx_last` appears once at the end, and interrupt flag bit 2 (transmit done) is raised only when the last-segment descriptor is written back.
- R9: A segment of length zero sends no bytes and marks its frame bad: the last-segment write-back has bit 23 set, and interrupt flag bit 3 is raised instead of bit 2.
- R10: Interrupt flags are write-one-to-clear through offset 0x3E; bits written as zero keep their value, and a flag being raised in the same cycle wins over the clear.
- R11: A poll that arrives while the engine is busy is remembered: when the engine next meets a descriptor it does not own, it re-reads that descriptor once before going idle.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| irq_stat | output | 16 | Sticky interrupt flags (bit 2 done, bit 3 error, bit 7 unavailable) |
| busy | output | 1 | Engine is walking the ring |
| rd_req | output | 1 | Memory read request, held until `rd_valid` |
| rd_addr | output | 64 | Word-aligned read address |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 32 | Read data, little-endian |
| wr_req | output | 1 | Status write-back request, held until `wr_ack` |
| wr_addr | output | 64 | Write-back address |
| wr_data | output | 32 | Write-back status word |
| wr_ack | input | 1 | Write accepted this cycle |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink accepts the byte |

## Verification
The assertions assume that memory answers a read only while `rd_req` is high and acknowledges a write only while `wr_req` is high, each for a single cycle per transfer, and that configuration writes to the base registers happen only while the engine is idle. The bench's memory model responds one wait cycle after a request is seen and acknowledges writes in the first cycle they are offered, and the stimulus writes the base before any poll. Backpressure on the stream is varied between always-ready, alternating and fully stalled so the hold property sees both accepted and refused bytes.

// File: rtl/txring_engine.sv
module txring_engine #(
  parameter int AW      = 64,
  parameter int LW      = 14,
  parameter int ERR_BIT = 23,
  parameter logic [7:0] OFS_BLO  = 8'h20,
  parameter logic [7:0] OFS_BHI  = 8'h24,
  parameter logic [7:0] OFS_POLL = 8'h38,
  parameter logic [7:0] OFS_ISR  = 8'h3E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [15:0]   irq_stat,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_ack,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready
);
  localparam int HW = AW - 32;
  localparam logic [AW-1:0] STRIDE = AW'(16);

  typedef enum logic [2:0] {S_IDLE, S_DESC, S_BUF, S_SEND, S_WB} state_t;

  state_t        state;
  logic [AW-1:0] base, cur, bptr;
  logic [1:0]    didx;
  logic [31:0]   st;
  logic [31:0]   word;
  logic [LW-1:0] rem;
  logic          ferr, pend;
  logic [15:0]   isr;

  wire poll   = cfg_we && cfg_addr == OFS_POLL && cfg_wdata[6];
  wire wr_blo = cfg_we && cfg_addr == OFS_BLO;
  wire wr_bhi = cfg_we && cfg_addr == OFS_BHI;
  wire [15:0] clr = (cfg_we && cfg_addr == OFS_ISR) ? cfg_wdata[15:0] : 16'h0;

  wire desc_beat = state == S_DESC && rd_valid;
  wire not_owned = desc_beat && didx == 2'd0 && !rd_data[31];
  wire wb_done   = state == S_WB && wr_ack;
  wire seg_last  = st[28];
  wire len_zero  = st[LW-1:0] == '0;
  wire take      = state == S_SEND && tx_ready;

  logic [15:0] setv;
  always_comb begin
    setv = 16'h0;
    setv[7] = not_owned;
    setv[2] = wb_done && seg_last && !ferr;
    setv[3] = wb_done && seg_last && ferr;
  end

  logic [AW-1:0] nbase;
  always_comb begin
    nbase = base;
    if (wr_blo) nbase[31:0] = {cfg_wdata[31:8], 8'h00};
    if (wr_bhi) nbase[AW-1:32] = cfg_wdata[HW-1:0];
  end

  assign busy     = state != S_IDLE;
  assign irq_stat = isr;
  assign rd_req   = state == S_DESC || state == S_BUF;
  assign rd_addr  = (state == S_DESC) ? cur + {{(AW-4){1'b0}}, didx, 2'b00}
                                      : {bptr[AW-1:2], 2'b00};
  assign wr_req   = state == S_WB;
  assign wr_addr  = cur;

  logic [31:0] wb_word;
  always_comb begin
    wb_word = {1'b0, st[30:0]};
    if (seg_last && ferr) wb_word[ERR_BIT] = 1'b1;
  end
  assign wr_data  = wb_word;

  wire [31:0] lane = word >> {bptr[1:0], 3'b000};
  assign tx_valid = state == S_SEND;
  assign tx_data  = lane[7:0];
  assign tx_last  = state == S_SEND && rem == LW'(1) && seg_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      base  <= '0;
      cur   <= '0;
      bptr  <= '0;
      didx  <= '0;
      st    <= '0;
      word  <= '0;
      rem   <= '0;
      ferr  <= 1'b0;
      pend  <= 1'b0;
      isr   <= '0;
    end else begin
      isr <= (isr & ~clr) | setv;
      if (wr_blo || wr_bhi) begin
        base <= nbase;
        if (state == S_IDLE) cur <= nbase;
      end
      if (poll && state != S_IDLE) pend <= 1'b1;

      case (state)
        S_IDLE: if (poll) begin
          state <= S_DESC;
          didx  <= '0;
          pend  <= 1'b0;
        end
        S_DESC: if (rd_valid) begin
          case (didx)
            2'd0: begin
              st <= rd_data;
              if (!rd_data[31]) begin
                if (pend || poll) pend <= 1'b0;
                else              state <= S_IDLE;
              end else didx <= 2'd1;
            end
            2'd1: didx <= 2'd2;
            2'd2: begin
              bptr[31:0] <= rd_data;
              didx <= 2'd3;
            end
            default: begin
              bptr[AW-1:32] <= rd_data[HW-1:0];
              ferr <= (st[29] ? 1'b0 : ferr) | len_zero;
              rem  <= st[LW-1:0];
              state <= len_zero ? S_WB : S_BUF;
            end
          endcase
        end
        S_BUF: if (rd_valid) begin
          word  <= rd_data;
          state <= S_SEND;
        end
        S_SEND: if (take) begin
          bptr <= bptr + AW'(1);
          rem  <= rem - LW'(1);
          if (rem == LW'(1))          state <= S_WB;
          else if (bptr[1:0] == 2'd3) state <= S_BUF;
        end
        S_WB: if (wr_ack) begin
          cur   <= st[30] ? base : cur + STRIDE;
          didx  <= '0;
          state <= S_DESC;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_engine_chk.sv
module txring_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_req,
  input logic [63:0] rd_addr,
  input logic        rd_valid,
  input logic        wr_req,
  input logic [63:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        wr_ack,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        tx_ready
);
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_req && !tx_valid));

  assert_rd_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00);

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_wb_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !wr_data[31]);

  assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_wb_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (!tx_valid && !rd_req));

  assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
endmodule

bind txring_engine txring_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
);

// File: tb/txring_engine_bench.sv
module txring_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [15:0] irq_stat;
  logic        busy, rd_req, wr_req, tx_valid, tx_last;
  logic [63:0] rd_addr, wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  tx_data;
  logic        rd_valid = 1'b0, wr_ack = 1'b0, tx_ready = 1'b0;
  logic [31:0] rd_data = 32'h0;

  txring_engine u_txring_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_stat(irq_stat), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready)
  );

  logic [31:0] mem [0:1023];
  logic [11:0] rlog [0:63];
  logic [11:0] wlog_a [0:7];
  logic [31:0] wlog_d [0:7];
  logic [15:0] wirq [0:7];
  logic [7:0]  bytes [0:127];
  logic        lasts [0:127];
  int rn = 0, wn = 0, bn = 0;
  int rd_lat = 0;
  int clr_tok = 0, seen_tok = 0;
  int rdy_mode = 0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  function automatic logic [7:0] fpat(input logic [11:0] a);
    return 8'(a * 7 + 3);
  endfunction

  always @(negedge clk) begin
    if (clr_tok != seen_tok) begin
      rn = 0; wn = 0; bn = 0;
      seen_tok = clr_tok;
    end
    if (rd_req) begin
      if (rd_lat == 1) begin
        rd_valid = 1'b1;
        rd_data  = mem[rd_addr[11:2]];
        if (rn < 64) rlog[rn] = rd_addr[11:0];
        rn = rn + 1;
        rd_lat = 0;
      end else begin
        rd_valid = 1'b0;
        rd_lat = rd_lat + 1;
      end
    end else begin
      rd_valid = 1'b0;
      rd_lat = 0;
    end
    if (wr_req && !wr_ack) begin
      wr_ack = 1'b1;
      mem[wr_addr[11:2]] = wr_data;
      if (wn < 8) begin
        wlog_a[wn] = wr_addr[11:0];
        wlog_d[wn] = wr_data;
        wirq[wn]   = irq_stat;
      end
      wn = wn + 1;
    end else wr_ack = 1'b0;
    if (rdy_mode == 0)      tx_ready = 1'b1;
    else if (rdy_mode == 1) tx_ready = ~tx_ready;
    else                    tx_ready = 1'b0;
    if (tx_valid && tx_ready) begin
      if (bn < 128) begin
        bytes[bn] = tx_data;
        lasts[bn] = tx_last;
      end
      bn = bn + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_logs();
    @(negedge clk);
    clr_tok++;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic put_desc(input logic [11:0] da, input logic [31:0] stw, input logic [31:0] buf_a);
    mem[da[11:2]]     = stw;
    mem[da[11:2] + 1] = 32'h0000_BEEF;
    mem[da[11:2] + 2] = buf_a;
    mem[da[11:2] + 3] = 32'h0;
  endtask

  localparam logic [25:0] VEC [0:5] = '{
    {14'd60, 12'h400}, {14'd1,  12'h501}, {14'd2, 12'h603},
    {14'd7,  12'h702}, {14'd64, 12'h801}, {14'd5, 12'h9FE}
  };

  initial begin
    for (int w = 0; w < 1024; w++)
      mem[w] = {fpat(12'(4*w+3)), fpat(12'(4*w+2)), fpat(12'(4*w+1)), fpat(12'(4*w))};
    repeat (4) @(negedge clk);
    chk(irq_stat == 16'h0, "R1 irq after reset", irq_stat, 0);
    chk(!busy && !rd_req && !wr_req && !tx_valid, "R1 quiet after reset",
        {busy, rd_req, wr_req, tx_valid}, 0);
    rst_n = 1'b1;
    cfg_write(8'h20, 32'h0000_01AB);
    cfg_write(8'h24, 32'h0);

    for (int k = 0; k < 6; k++) begin
      int slot, ns, len, mism, lastbad;
      logic [11:0] da, nda, boff;
      logic [31:0] stw;
      slot = k % 4;
      ns   = (slot + 1) % 4;
      da   = 12'(12'h100 + slot * 16);
      nda  = 12'(12'h100 + ns * 16);
      len  = int'(VEC[k][25:12]);
      boff = VEC[k][11:0];
      stw  = 32'hB000_0000 | (slot == 3 ? 32'h4000_0000 : 32'h0) | 32'(len);
      put_desc(da, stw, {20'h0, boff});
      mem[nda[11:2]] = 32'h0;
      rdy_mode = k % 2;
      clear_logs();
      cfg_write(8'h38, 32'h40);
      wait_idle();
      chk(rlog[0] == da, "R2 first fetch address", rlog[0], da);
      chk(rlog[3] == da + 12'd12, "R3 fourth descriptor word", rlog[3], da + 12'd12);
      chk(bn == len, "R5 byte count", bn, len);
      mism = 0; lastbad = 0;
      for (int i = 0; i < len && i < 128; i++) begin
        if (bytes[i] != fpat(12'(boff + i))) mism++;
        if (lasts[i] != (i == len - 1)) lastbad++;
      end
      chk(mism == 0, "R5 byte values", mism, 0);
      chk(lastbad == 0, "R5 last marker", lastbad, 0);
      chk(wn == 1 && wlog_a[0] == da, "R6 write-back address", wlog_a[0], da);
      chk(wlog_d[0] == (stw & 32'h7FFF_FFFF), "R6 write-back data", wlog_d[0], stw & 32'h7FFF_FFFF);
      chk(rlog[rn-1] == nda, "R7 next fetch address", rlog[rn-1], nda);
      chk(irq_stat == 16'h0084, "R8 done and unavailable flags", irq_stat, 16'h0084);
      cfg_write(8'h3E, 32'hFFFF);
    end

    // R4: descriptor not owned at slot 2
    mem[12'h120 >> 2] = 32'h3000_0010;
    rdy_mode = 0;
    clear_logs();
    cfg_write(8'h38, 32'h40);
    wait_idle();
    chk(wn == 0 && bn == 0, "R4 nothing moved", {wn, bn}, 0);
    chk(rn == 1 && rlog[0] == 12'h120, "R4 single status read", rlog[0], 12'h120);
    chk(irq_stat == 16'h0080, "R4 unavailable flag", irq_stat, 16'h0080);

    // R10: write-one-to-clear leaves other bits
    cfg_write(8'h3E, 32'h0004);
    chk(irq_stat == 16'h0080, "R10 zero bits kept", irq_stat, 16'h0080);
    cfg_write(8'h3E, 32'h0080);
    chk(irq_stat == 16'h0000, "R10 one bits cleared", irq_stat, 0);

    // R8: two-segment frame in slots 2 and 3 (end of ring)
    put_desc(12'h120, 32'hA000_0003, 32'h0000_0A00);
    put_desc(12'h130, 32'hD000_0005, 32'h0000_0B01);
    mem[12'h100 >> 2] = 32'h0;
    clear_logs();
    cfg_write(8'h38, 32'h40);
    wait_idle();
    begin
      int mism, nl;
      mism = 0; nl = 0;
      for (int i = 0; i < 8; i++) begin
        if (bytes[i] != (i < 3 ? fpat(12'(12'hA00 + i)) : fpat(12'(12'hB01 + i - 3)))) mism++;
        if (lasts[i]) nl++;
      end
      chk(bn == 8 && mism == 0, "R8 frame bytes", {bn, mism}, 8 << 32);
      chk(nl == 1 && lasts[7], "R8 single last marker", nl, 1);
    end
    chk(wn == 2 && wirq[0][2] == 1'b0, "R8 no flag at first segment", wirq[0], 0);
    chk(wlog_d[0] == 32'h2000_0003, "R6 first segment write-back", wlog_d[0], 32'h2000_0003);
    chk(irq_stat[2] && !irq_stat[3], "R8 done flag after last", irq_stat, 16'h0084);
    chk(rlog[rn-1] == 12'h100, "R7 wrap to base", rlog[rn-1], 12'h100);
    cfg_write(8'h3E, 32'hFFFF);

    // R9: zero-length frame at slot 0
    put_desc(12'h100, 32'hB000_0000, 32'h0);
    mem[12'h110 >> 2] = 32'h0;
    clear_logs();
    cfg_write(8'h38, 32'h40);
    wait_idle();
    chk(bn == 0, "R9 no bytes", bn, 0);
    chk(wn == 1 && wlog_d[0] == 32'h3080_0000, "R9 error bit in write-back", wlog_d[0], 32'h3080_0000);
    chk(irq_stat == 16'h0088, "R9 error flag instead of done", irq_stat, 16'h0088);
    cfg_write(8'h3E, 32'hFFFF);

    // R11 and R12: poll during a stalled frame at slot 1
    put_desc(12'h110, 32'hB000_0004, 32'h0000_0C00);
    mem[12'h120 >> 2] = 32'h0;
    rdy_mode = 2;
    clear_logs();
    cfg_write(8'h38, 32'h40);
    repeat (20) @(negedge clk);
    begin
      logic [7:0] d0;
      d0 = tx_data;
      chk(tx_valid && bn == 0, "R12 byte offered while stalled", {tx_valid, bn}, 1 << 32);
      cfg_write(8'h38, 32'h40);
      repeat (5) @(negedge clk);
      chk(tx_valid && tx_data == d0, "R12 byte held", tx_data, d0);
    end
    rdy_mode = 0;
    wait_idle();
    begin
      int hits;
      hits = 0;
      for (int i = 0; i < rn && i < 64; i++) if (rlog[i] == 12'h120) hits++;
      chk(hits == 2, "R11 pending poll re-reads", hits, 2);
    end
    chk(bn == 4 && bytes[3] == fpat(12'hC03), "R5 stalled frame bytes", bn, 4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule